// File: doc/BRIEF.md
# Capture/Compare Free-Running Timer

A 16-bit timer that counts once per tick enable and raises three events: a capture of the count when a chosen edge arrives on an input pin, a compare match that drives an output pin to a programmed level, and a rollover of the count. Each event sets a sticky status flag. An interrupt request for each flag is gated by its own enable bit.

A processor reaches the block through an 8-bit register bus. The bus covers the control byte, the status byte, and the high and low bytes of the count, of a second view of the count, of the capture register and of the compare register. A flag is cleared by a two-step handshake: the status byte is read while the flag is set, and then the low byte that belongs to that flag is accessed. Reading a count high byte freezes the low byte, so that a two-step read returns one coherent 16-bit value.

Reset does not reach every part of the block. The edge-select bit, the capture register, the compare register and the flags keep their values through reset. The count, the other control bits and the compare pin are reset.

Top module: `capcmp_timer`

## Requirements
- R1: The control byte (address 0) holds capture interrupt enable in bit 7, compare interrupt enable in bit 6, overflow interrupt enable in bit 5, edge select in bit 1 and output level in bit 0. Bits 4 to 2 always read as 0. Reset clears bits 7, 6, 5 and 0 and leaves bit 1 unchanged.
- R2: The count resets to 0xFFFC. It advances by one on each clock where tick_en is 1 and holds its value otherwise. The count is read at address 6 (high byte) and address 7 (low byte).
- R3: When the count wraps from 0xFFFF to 0x0000, the overflow flag (status bit 5, address 1) sets. irq_ovf is 1 exactly when that flag and control bit 5 are both 1.
- R4: The capture input passes through two synchronizing flops. After that, with edge select at 1 a rising edge captures and with edge select at 0 a falling edge captures. The opposite edge does nothing. A capture copies the count into the capture register (address 2 high byte, address 3 low byte).
- R5: A capture sets the capture flag (status bit 7). irq_cap is 1 exactly when that flag and control bit 7 are both 1.
- R6: When a tick moves the count onto the compare value (address 4 high byte, address 5 low byte), cmp_out takes the value of control bit 0 and the compare flag (status bit 6) sets. irq_cmp is 1 exactly when that flag and control bit 6 are both 1.
- R7: Reset drives cmp_out to 0. The pin changes only on a compare match, so it stays 0 until the output level bit is 1 when a match occurs.
- R8: A flag clears only when a status read saw it set and is followed by the matching low-byte access: a read of address 3 for capture, a write of address 5 for compare, a read of address 7 for overflow. Such an access without that earlier status read leaves the flag set.
- R9: A read of address 6 or address 8 freezes the low byte of the count. The next read of address 7 or address 9 returns the frozen byte. Addresses 8 and 9 read the count like 6 and 7, but a read of address 9 never clears the overflow flag.
- R10: A write to the compare high byte blocks compare matches until the compare low byte is written.
- R11: Reset leaves the capture register and the compare register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count advance enable |
| bus_addr | input | 4 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address while bus_rd is 1 |
| cap_in | input | 1 | Capture input pin, asynchronous |
| cmp_out | output | 1 | Compare output pin |
| irq_cap | output | 1 | Capture interrupt request |
| irq_cmp | output | 1 | Compare interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
A count that has lost step appears in the next bus read of the count bytes. It also shifts the cycle at which irq_ovf and cmp_out change, and the bench predicts that cycle exactly from the ticks it issued. A flag-clear handshake that has lost its armed state shows on the irq pin in the cycle after the low-byte access. Either a request stays up that should have dropped, or one drops without the status read that should come first. A wrong synchronizer depth or wrong edge polarity shows in the capture register read a few cycles after the pin changes, because the count is held still while the capture happens.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [3:0] {
    A_CTRL   = 4'd0,
    A_STAT   = 4'd1,
    A_CAP_H  = 4'd2,
    A_CAP_L  = 4'd3,
    A_CMP_H  = 4'd4,
    A_CMP_L  = 4'd5,
    A_CNT_H  = 4'd6,
    A_CNT_L  = 4'd7,
    A_ALT_H  = 4'd8,
    A_ALT_L  = 4'd9
  } tmr_addr_e;

  localparam int unsigned CTRL_IE_CAP = 7;
  localparam int unsigned CTRL_IE_CMP = 6;
  localparam int unsigned CTRL_IE_OVF = 5;
  localparam int unsigned CTRL_EDGE   = 1;
  localparam int unsigned CTRL_LEVEL  = 0;

  function automatic logic [15:0] tmr_next(input logic [15:0] v);
    return v + 16'd1;
  endfunction

  function automatic logic tmr_wraps(input logic [15:0] v);
    return &v;
  endfunction

  function automatic logic edge_seen(input logic rise_sel, input logic cur, input logic prev);
    return rise_sel ? (cur & ~prev) : (~cur & prev);
  endfunction

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter logic [15:0] RST_VAL = 16'hFFFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             hi_rd,
  input  logic             lo_rd,
  output logic [CNT_W-1:0] cnt_q,
  output logic [7:0]       lo_view,
  output logic             wrap_evt
);
  logic [7:0] lo_frozen;
  logic       frozen_vld;

  assign wrap_evt = tick & tmr_wraps(cnt_q);
  assign lo_view  = frozen_vld ? lo_frozen : cnt_q[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= RST_VAL;
      lo_frozen  <= '0;
      frozen_vld <= 1'b0;
    end else begin
      if (tick) cnt_q <= tmr_next(cnt_q);
      if (hi_rd) begin
        lo_frozen  <= cnt_q[7:0];
        frozen_vld <= 1'b1;
      end else if (lo_rd) begin
        frozen_vld <= 1'b0;
      end
    end
  end

  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt_q == tmr_next($past(cnt_q)));
  assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> cnt_q == '0);
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  logic             rise_sel,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap_q,
  output logic             cap_evt
);
  logic [SYNC-1:0] sync_q;
  logic            prev_q;
  logic            synced;

  assign synced  = sync_q[SYNC-1];
  assign cap_evt = edge_seen(rise_sel, synced, prev_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], pin};
      prev_q <= synced;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_evt) cap_q <= cnt;
  end

  assert_cap_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_q == $past(cnt));
  assert_cap_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(cap_q));
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic             hi_wr,
  input  logic             lo_wr,
  input  logic [7:0]       wdata,
  input  logic             level,
  output logic [CNT_W-1:0] cmp_q,
  output logic             hit,
  output logic             pin_q
);
  logic blocked_q;

  assign hit = tick & ~blocked_q & (tmr_next(cnt) == cmp_q);

  always_ff @(posedge clk) begin
    if (hi_wr) cmp_q[CNT_W-1 -: 8] <= wdata;
    if (lo_wr) cmp_q[7:0]          <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blocked_q <= 1'b0;
      pin_q     <= 1'b0;
    end else begin
      if (hi_wr)      blocked_q <= 1'b1;
      else if (lo_wr) blocked_q <= 1'b0;
      if (hit) pin_q <= level;
    end
  end

  assert_pin_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pin_q == $past(level));
  assert_pin_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(pin_q));
  assert_block_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_q |-> !hit);
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter logic [15:0] RST_VAL = 16'hFFFC,
  parameter int unsigned SYNC    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic [3:0] bus_addr,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       cap_in,
  output logic       cmp_out,
  output logic       irq_cap,
  output logic       irq_cmp,
  output logic       irq_ovf
);
  localparam int unsigned HI = CNT_W - 1;

  logic ie_cap, ie_cmp, ie_ovf, level;
  logic rise_sel;
  logic f_cap, f_cmp, f_ovf;
  logic arm_cap, arm_cmp, arm_ovf;

  logic [CNT_W-1:0] cnt_q, cap_q, cmp_q;
  logic [7:0]       lo_view;
  logic             wrap_evt, cap_evt, cmp_hit;

  logic rd_ctrl, rd_stat, rd_cap_l, rd_cnt_h, rd_cnt_l, rd_alt_h, rd_alt_l;
  logic wr_ctrl, wr_cmp_h, wr_cmp_l;
  logic clr_cap, clr_cmp, clr_ovf;

  assign rd_ctrl  = bus_rd & (bus_addr == A_CTRL);
  assign rd_stat  = bus_rd & (bus_addr == A_STAT);
  assign rd_cap_l = bus_rd & (bus_addr == A_CAP_L);
  assign rd_cnt_h = bus_rd & (bus_addr == A_CNT_H);
  assign rd_cnt_l = bus_rd & (bus_addr == A_CNT_L);
  assign rd_alt_h = bus_rd & (bus_addr == A_ALT_H);
  assign rd_alt_l = bus_rd & (bus_addr == A_ALT_L);
  assign wr_ctrl  = bus_wr & (bus_addr == A_CTRL);
  assign wr_cmp_h = bus_wr & (bus_addr == A_CMP_H);
  assign wr_cmp_l = bus_wr & (bus_addr == A_CMP_L);

  assign clr_cap = arm_cap & rd_cap_l;
  assign clr_cmp = arm_cmp & wr_cmp_l;
  assign clr_ovf = arm_ovf & rd_cnt_l;

  tmr_counter #(.CNT_W(CNT_W), .RST_VAL(RST_VAL)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_en),
    .hi_rd    (rd_cnt_h | rd_alt_h),
    .lo_rd    (rd_cnt_l | rd_alt_l),
    .cnt_q    (cnt_q),
    .lo_view  (lo_view),
    .wrap_evt (wrap_evt)
  );

  tmr_capture #(.CNT_W(CNT_W), .SYNC(SYNC)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (cap_in),
    .rise_sel (rise_sel),
    .cnt      (cnt_q),
    .cap_q    (cap_q),
    .cap_evt  (cap_evt)
  );

  tmr_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_en),
    .cnt   (cnt_q),
    .hi_wr (wr_cmp_h),
    .lo_wr (wr_cmp_l),
    .wdata (bus_wdata),
    .level (level),
    .cmp_q (cmp_q),
    .hit   (cmp_hit),
    .pin_q (cmp_out)
  );

  // control byte: enables and level are reset, edge select is not
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_cap <= 1'b0;
      ie_cmp <= 1'b0;
      ie_ovf <= 1'b0;
      level  <= 1'b0;
    end else if (wr_ctrl) begin
      ie_cap <= bus_wdata[CTRL_IE_CAP];
      ie_cmp <= bus_wdata[CTRL_IE_CMP];
      ie_ovf <= bus_wdata[CTRL_IE_OVF];
      level  <= bus_wdata[CTRL_LEVEL];
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && wr_ctrl) rise_sel <= bus_wdata[CTRL_EDGE];
  end

  // flags keep their value through reset; a new event wins over a clear
  always_ff @(posedge clk) begin
    if (cap_evt)      f_cap <= 1'b1;
    else if (clr_cap) f_cap <= 1'b0;
    if (cmp_hit)      f_cmp <= 1'b1;
    else if (clr_cmp) f_cmp <= 1'b0;
    if (wrap_evt)     f_ovf <= 1'b1;
    else if (clr_ovf) f_ovf <= 1'b0;
  end

  // first half of the clear handshake
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_cap <= 1'b0;
      arm_cmp <= 1'b0;
      arm_ovf <= 1'b0;
    end else begin
      if (rd_stat && f_cap) arm_cap <= 1'b1;
      else if (rd_cap_l)    arm_cap <= 1'b0;
      if (rd_stat && f_cmp) arm_cmp <= 1'b1;
      else if (wr_cmp_l)    arm_cmp <= 1'b0;
      if (rd_stat && f_ovf) arm_ovf <= 1'b1;
      else if (rd_cnt_l)    arm_ovf <= 1'b0;
    end
  end

  assign irq_cap = f_cap & ie_cap;
  assign irq_cmp = f_cmp & ie_cmp;
  assign irq_ovf = f_ovf & ie_ovf;

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_rd) begin
      case (bus_addr)
        A_CTRL:  bus_rdata = {ie_cap, ie_cmp, ie_ovf, 3'b000, rise_sel, level};
        A_STAT:  bus_rdata = {f_cap, f_cmp, f_ovf, 5'b00000};
        A_CAP_H: bus_rdata = cap_q[HI -: 8];
        A_CAP_L: bus_rdata = cap_q[7:0];
        A_CMP_H: bus_rdata = cmp_q[HI -: 8];
        A_CMP_L: bus_rdata = cmp_q[7:0];
        A_CNT_H, A_ALT_H: bus_rdata = cnt_q[HI -: 8];
        A_CNT_L, A_ALT_L: bus_rdata = lo_view;
        default: bus_rdata = 8'h00;
      endcase
    end
  end

  assert_ctrl_gaps_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl |-> bus_rdata[4:2] == 3'b000);
  assert_ovf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> f_ovf);
  assert_cap_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> f_cap);
  assert_cmp_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit |=> f_cmp);
  assert_ovf_noarm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (f_ovf && !arm_ovf) |=> f_ovf);
  assert_alt_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (f_ovf && rd_alt_l) |=> f_ovf);
endmodule

// File: tb/capcmp_timer_tb.sv
module capcmp_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cap_in = 1'b0;
  logic       cmp_out, irq_cap, irq_cmp, irq_ovf;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_cnt;

  always #10 clk = ~clk;

  capcmp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_in(cap_in), .cmp_out(cmp_out), .irq_cap(irq_cap), .irq_cmp(irq_cmp),
    .irq_ovf(irq_ovf)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
      exp_cnt = exp_cnt + 16'd1;
    end
  endtask

  task automatic rd16(input logic [3:0] hi_a, output logic [15:0] v);
    logic [7:0] h, l;
    rd(hi_a, h);
    rd(hi_a + 4'd1, l);
    v = {h, l};
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    exp_cnt = 16'hFFFC;
  endtask

  task automatic set_cmp(input logic [15:0] v);
    wr(4'd4, v[15:8]);
    wr(4'd5, v[7:0]);
  endtask

  task automatic t_reset;
    logic [7:0] d; logic [15:0] v;
    rd(4'd0, d);
    check("R1 ctrl after reset", {8'h0, d & 8'hFD}, 16'h0000);
    rd16(4'd6, v);
    check("R2 count reset value", v, 16'hFFFC);
    check("R7 pin low after reset", {15'h0, cmp_out}, 16'h0);
    check("R3 irq low after reset", {13'h0, irq_cap, irq_cmp, irq_ovf}, 16'h0);
  endtask

  task automatic t_ctrl;
    logic [7:0] d;
    wr(4'd0, 8'hFF);
    rd(4'd0, d);
    check("R1 reserved bits read zero", {8'h0, d}, 16'h00E3);
    wr(4'd0, 8'h00);
    rd(4'd0, d);
    check("R1 ctrl cleared", {8'h0, d}, 16'h0000);
  endtask

  task automatic t_count_ovf;
    logic [15:0] v; logic [7:0] d;
    ticks(3);
    rd16(4'd6, v);
    check("R2 count after 3 ticks", v, exp_cnt);
    rd(4'd1, d);
    check("R3 no overflow before wrap", {8'h0, d & 8'h20}, 16'h0);
    ticks(1);
    check("R3 irq gated off", {15'h0, irq_ovf}, 16'h0);
    wr(4'd0, 8'h20);
    check("R3 irq after wrap with enable", {15'h0, irq_ovf}, 16'h1);
    rd(4'd7, d);
    check("R8 no clear without status read", {15'h0, irq_ovf}, 16'h1);
    rd(4'd1, d);
    check("R3 status overflow bit", {8'h0, d}, 16'h0020);
    rd(4'd9, d);
    check("R9 alternate low keeps flag", {15'h0, irq_ovf}, 16'h1);
    rd(4'd7, d);
    check("R8 clear after handshake", {15'h0, irq_ovf}, 16'h0);
  endtask

  task automatic t_freeze;
    logic [7:0] h, l; logic [15:0] snap;
    ticks(250);
    snap = exp_cnt;
    rd(4'd6, h);
    ticks(5);
    rd(4'd7, l);
    check("R9 frozen low byte", {h, l}, snap);
    rd(4'd8, h);
    snap = exp_cnt;
    ticks(2);
    rd(4'd9, l);
    check("R9 alternate frozen read", {h, l}, snap);
  endtask

  task automatic t_capture;
    logic [15:0] v, first; logic [7:0] d;
    wr(4'd0, 8'h82);
    @(negedge clk); cap_in = 1'b1;
    repeat (4) @(negedge clk);
    first = exp_cnt;
    rd16(4'd2, v);
    check("R4 rising edge captured", v, first);
    check("R5 capture irq", {15'h0, irq_cap}, 16'h1);
    rd(4'd1, d);
    rd(4'd3, d);
    check("R8 capture flag cleared", {15'h0, irq_cap}, 16'h0);
    ticks(3);
    @(negedge clk); cap_in = 1'b0;
    repeat (4) @(negedge clk);
    rd16(4'd2, v);
    check("R4 falling ignored when rising selected", v, first);
    check("R5 no flag on ignored edge", {15'h0, irq_cap}, 16'h0);
    wr(4'd0, 8'h80);
    @(negedge clk); cap_in = 1'b1;
    repeat (4) @(negedge clk);
    ticks(2);
    @(negedge clk); cap_in = 1'b0;
    repeat (4) @(negedge clk);
    rd16(4'd2, v);
    check("R4 falling edge captured", v, exp_cnt);
    check("R5 capture irq on falling", {15'h0, irq_cap}, 16'h1);
    rd(4'd1, d);
    rd(4'd3, d);
  endtask

  task automatic t_compare;
    logic [7:0] d;
    wr(4'd0, 8'h40);
    set_cmp(exp_cnt + 16'd3);
    ticks(3);
    check("R7 pin low when level 0", {15'h0, cmp_out}, 16'h0);
    check("R6 compare irq", {15'h0, irq_cmp}, 16'h1);
    rd(4'd1, d);
    set_cmp(exp_cnt + 16'd4);
    check("R8 compare flag cleared", {15'h0, irq_cmp}, 16'h0);
    wr(4'd0, 8'h41);
    ticks(3);
    check("R6 no change before match", {15'h0, cmp_out}, 16'h0);
    ticks(1);
    check("R6 pin takes level 1", {15'h0, cmp_out}, 16'h1);
    check("R6 compare irq again", {15'h0, irq_cmp}, 16'h1);
    rd(4'd1, d);
    wr(4'd0, 8'h40);
    set_cmp(exp_cnt + 16'd2);
    ticks(2);
    check("R6 pin takes level 0", {15'h0, cmp_out}, 16'h0);
    rd(4'd1, d);
    wr(4'd0, 8'h41);
    set_cmp(exp_cnt + 16'd3);
    check("R8 flag cleared before block test", {15'h0, irq_cmp}, 16'h0);
    wr(4'd4, 8'(((exp_cnt + 16'd3) >> 8)));
    ticks(3);
    check("R10 pin blocked after high write", {15'h0, cmp_out}, 16'h0);
    check("R10 flag blocked after high write", {15'h0, irq_cmp}, 16'h0);
  endtask

  task automatic t_reset_keep;
    logic [15:0] cap_before, cmp_before, v; logic [7:0] d;
    wr(4'd0, 8'h43);
    rd16(4'd2, cap_before);
    rd16(4'd4, cmp_before);
    do_reset();
    rd16(4'd2, v);
    check("R11 capture kept through reset", v, cap_before);
    rd16(4'd4, v);
    check("R11 compare kept through reset", v, cmp_before);
    rd(4'd0, d);
    check("R1 edge bit kept through reset", {8'h0, d}, 16'h0002);
    rd16(4'd6, v);
    check("R2 count reset again", v, 16'hFFFC);
    check("R7 pin low after second reset", {15'h0, cmp_out}, 16'h0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    exp_cnt = 16'hFFFC;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    // put the reset-immune state into a known condition
    wr(4'd0, 8'h00);
    rd(4'd1, d); rd(4'd3, d); rd(4'd7, d);
    rd16(4'd6, exp_cnt);
    set_cmp(exp_cnt + 16'h8000);
    t_ctrl();
    t_count_ovf();
    t_freeze();
    t_capture();
    t_compare();
    t_reset_keep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule